// File: doc/BRIEF.md
# A/B Boot Slot Selector with Trial Watchdog and Version Floor

This block decides which of two firmware image slots runs after every system boot event. It keeps a small persistent state: the known-good slot, a pending flag that arms a trial of the other slot on the next boot, whether a trial is running, and the version of the image stored in each slot. A verified update, signalled by a strobe together with the candidate's version number, is recorded for the slot that is not known-good. The next-boot pointer then moves to that slot by setting one bit.

A trial boot is supervised. The newly started image must raise a heartbeat within a fixed number of clock cycles. The first heartbeat makes the trial slot the known-good one. If no heartbeat arrives in time, the block raises a one-cycle watchdog reset and falls back to the known-good slot in the same step. A version floor, taken from one-time-programmable fuses, gates both the acceptance of updates and every boot decision. The block keeps the highest floor it has seen since power-on, so the floor can never move down.

Top module: `boot_slot_sel`

## Requirements
- R1: After power-on reset, slot 0 runs and is known-good, next_slot is 0, no trial is active, boot_en is 1, and wdt_reset, upd_accept and upd_reject are 0.
- R2: An update strobe with version greater than or equal to the effective floor, seen while neither a pending trial nor a running trial exists, gives a one-cycle upd_accept pulse on the next cycle, and next_slot becomes the slot that is not known-good (an equal version is accepted).
- R3: An update strobe with version strictly below the effective floor gives a one-cycle upd_reject pulse on the next cycle and leaves next_slot unchanged.
- R4: The effective floor is the largest fuse_floor value presented since power-on; lowering the input afterwards does not re-admit older versions.
- R5: A boot event (sys_boot high) while a trial is pending starts the other slot: boot_slot switches to it and trial_active is 1 from the next cycle.
- R6: A heartbeat during a trial makes the running slot known-good, clears trial_active and prevents any watchdog reset.
- R7: If no heartbeat arrives, wdt_reset is high for exactly one cycle, TIMEOUT_CYC cycles after trial_active first reads 1, and at that point boot_slot and good_slot both show the previous known-good slot and trial_active is 0.
- R8: A heartbeat in the same cycle as the watchdog expiry wins: the trial is committed and no wdt_reset is raised.
- R9: An update strobe is ignored (no accept or reject pulse, next_slot unchanged) while a trial is pending or running, or in a cycle with sys_boot high.
- R10: At a boot event, a pending image below the effective floor is not started, and the known-good slot boots instead. If the known-good slot is also below the floor, boot_en drops to 0.
- R11: A boot event during an unconfirmed trial returns boot_slot to the known-good slot with trial_active 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the persistent state |
| sys_boot | input | 1 | A system boot event: select and start a slot |
| upd_valid | input | 1 | Strobe: a fully verified image has been written |
| upd_version | input | VER_W | Version of the verified image |
| fuse_floor | input | VER_W | Minimum bootable version from the fuses |
| fw_alive | input | 1 | Heartbeat pulse from the running firmware |
| boot_slot | output | 1 | Slot currently selected to run |
| good_slot | output | 1 | Known-good slot |
| next_slot | output | 1 | Slot the next boot event will try |
| trial_active | output | 1 | A trial image is running under the watchdog |
| boot_en | output | 1 | An image at or above the floor is selected |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse with revert |
| upd_accept | output | 1 | One-cycle pulse: update recorded |
| upd_reject | output | 1 | One-cycle pulse: update refused by version floor |

## Verification
The heartbeat and the watchdog expiry can arrive in the same cycle. The bench provokes this by holding the heartbeat back until the last cycle of the trial window, counted from the boot event. It then expects a commit with no wdt_reset. A second collision is an update strobe in the same cycle as a boot event, or during the trial window. The outputs must show no accept or reject pulse and an unchanged next_slot. The accept/reject decision is swept over every pair of version and floor for a 4-bit version width, and the expected result is computed by comparing the two numbers.

// File: rtl/abslot_pkg.sv
package abslot_pkg;

    typedef enum logic [1:0] {
        PICK_TRIAL = 2'd0,
        PICK_GOOD  = 2'd1,
        PICK_NONE  = 2'd2
    } pick_e;

    // Boot choice: a pending trial image if it clears the floor, else the
    // known-good image if it clears the floor, else nothing bootable.
    function automatic pick_e pick_boot(input logic pend,
                                        input logic trial_ok,
                                        input logic good_ok);
        if (pend && trial_ok) begin
            return PICK_TRIAL;
        end else if (good_ok) begin
            return PICK_GOOD;
        end
        return PICK_NONE;
    endfunction

endpackage

// File: rtl/abs_ver_gate.sv
module abs_ver_gate #(
    parameter int VER_W = 8
) (
    input  logic [VER_W-1:0] version,
    input  logic [VER_W-1:0] floor_val,
    output logic             allowed
);
    // Equal to the floor is bootable; only strictly lower is refused.
    assign allowed = (version >= floor_val);
endmodule

// File: rtl/abs_floor_track.sv
module abs_floor_track #(
    parameter int VER_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [VER_W-1:0] fuse_in,
    output logic [VER_W-1:0] floor_eff
);
    logic [VER_W-1:0] floor_d;
    logic [VER_W-1:0] floor_q;

    always_comb begin
        floor_d = (fuse_in > floor_q) ? fuse_in : floor_q;
    end

    assign floor_eff = floor_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            floor_q <= '0;
        end else begin
            floor_q <= floor_d;
        end
    end
endmodule

// File: rtl/abs_hb_watchdog.sv
module abs_hb_watchdog #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic arm,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    assign expire = arm && (cnt_q == LAST);

    always_comb begin
        if (restart || !arm || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/boot_slot_sel.sv
module boot_slot_sel #(
    parameter int          VER_W       = 8,
    parameter int          TIMEOUT_CYC = 1024,
    parameter logic [7:0]  INIT_VER    = 8'd0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_boot,
    input  logic             upd_valid,
    input  logic [VER_W-1:0] upd_version,
    input  logic [VER_W-1:0] fuse_floor,
    input  logic             fw_alive,
    output logic             boot_slot,
    output logic             good_slot,
    output logic             next_slot,
    output logic             trial_active,
    output logic             boot_en,
    output logic             wdt_reset,
    output logic             upd_accept,
    output logic             upd_reject
);
    import abslot_pkg::*;

    localparam int NSLOT = 2;
    localparam logic [VER_W-1:0] VER_RST = VER_W'(INIT_VER);

    typedef struct packed {
        logic [NSLOT-1:0][VER_W-1:0] ver;
        logic good;
        logic pend;
        logic trial;
        logic run;
        logic halt;
        logic accept;
        logic reject;
        logic wdt;
    } sel_st_t;

    sel_st_t st_d;
    sel_st_t st_q;

    logic [VER_W-1:0] floor_eff;
    logic [NSLOT-1:0] slot_ok;
    logic             cand_ok;
    logic             wd_expire;
    logic             commit;
    logic             good_eff;
    logic             other;
    logic             reboot;
    pick_e            pick;

    abs_floor_track #(.VER_W(VER_W)) u_floor (
        .clk       (clk),
        .por_n     (por_n),
        .fuse_in   (fuse_floor),
        .floor_eff (floor_eff)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot_gate
        abs_ver_gate #(.VER_W(VER_W)) u_gate (
            .version   (st_q.ver[g]),
            .floor_val (floor_eff),
            .allowed   (slot_ok[g])
        );
    end

    abs_ver_gate #(.VER_W(VER_W)) u_cand_gate (
        .version   (upd_version),
        .floor_val (floor_eff),
        .allowed   (cand_ok)
    );

    abs_hb_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .por_n   (por_n),
        .arm     (st_q.trial),
        .restart (reboot),
        .expire  (wd_expire)
    );

    always_comb begin
        commit   = st_q.trial && fw_alive;
        good_eff = commit ? st_q.run : st_q.good;
        other    = ~good_eff;
        reboot   = sys_boot || (wd_expire && !fw_alive);
        pick     = pick_boot(st_q.pend, slot_ok[other], slot_ok[good_eff]);

        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.reject = 1'b0;
        st_d.wdt    = 1'b0;

        if (reboot) begin
            st_d.good = good_eff;
            st_d.pend = 1'b0;
            st_d.wdt  = wd_expire && !fw_alive;
            unique case (pick)
                PICK_TRIAL: begin
                    st_d.run   = other;
                    st_d.trial = 1'b1;
                    st_d.halt  = 1'b0;
                end
                PICK_GOOD: begin
                    st_d.run   = good_eff;
                    st_d.trial = 1'b0;
                    st_d.halt  = 1'b0;
                end
                default: begin
                    st_d.run   = good_eff;
                    st_d.trial = 1'b0;
                    st_d.halt  = 1'b1;
                end
            endcase
        end else if (commit) begin
            st_d.good  = st_q.run;
            st_d.trial = 1'b0;
        end else if (upd_valid && !st_q.pend && !st_q.trial) begin
            if (cand_ok) begin
                st_d.ver[other] = upd_version;
                st_d.pend       = 1'b1;
                st_d.accept     = 1'b1;
            end else begin
                st_d.reject     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{ver: {NSLOT{VER_RST}}, good: 1'b0, pend: 1'b0,
                      trial: 1'b0, run: 1'b0, halt: 1'b0,
                      accept: 1'b0, reject: 1'b0, wdt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_slot    = st_q.run;
    assign good_slot    = st_q.good;
    assign next_slot    = st_q.pend ? ~st_q.good : st_q.good;
    assign trial_active = st_q.trial;
    assign boot_en      = ~st_q.halt;
    assign wdt_reset    = st_q.wdt;
    assign upd_accept   = st_q.accept;
    assign upd_reject   = st_q.reject;
endmodule

// File: rtl/boot_slot_sel_chk.sv
module boot_slot_sel_chk (
    input logic clk,
    input logic por_n,
    input logic upd_valid,
    input logic fw_alive,
    input logic boot_slot,
    input logic good_slot,
    input logic trial_active,
    input logic boot_en,
    input logic wdt_reset,
    input logic upd_accept,
    input logic upd_reject
);
    // R7
    wdt_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_reset |=> !wdt_reset);

    // R7
    wdt_revert_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_reset |-> (!trial_active && boot_slot == good_slot));

    // R2
    acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(upd_accept && upd_reject));

    // R9
    trial_blocks_upd_chk: assert property (@(posedge clk) disable iff (!por_n)
        (trial_active && upd_valid) |=> !(upd_accept || upd_reject));

    // R6
    hb_commit_chk: assert property (@(posedge clk) disable iff (!por_n)
        (trial_active && fw_alive) |=> (!trial_active && good_slot == $past(boot_slot)));

    // R10
    trial_bootable_chk: assert property (@(posedge clk) disable iff (!por_n)
        trial_active |-> boot_en);
endmodule

bind boot_slot_sel boot_slot_sel_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .upd_valid    (upd_valid),
    .fw_alive     (fw_alive),
    .boot_slot    (boot_slot),
    .good_slot    (good_slot),
    .trial_active (trial_active),
    .boot_en      (boot_en),
    .wdt_reset    (wdt_reset),
    .upd_accept   (upd_accept),
    .upd_reject   (upd_reject)
);

// File: tb/boot_slot_sel_bench.sv
`timescale 1ns/1ps
module boot_slot_sel_bench;
    localparam int VW = 4;
    localparam int TO = 8;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          sys_boot = 1'b0;
    logic          upd_valid = 1'b0;
    logic [VW-1:0] upd_version = '0;
    logic [VW-1:0] fuse_floor = '0;
    logic          fw_alive = 1'b0;
    logic          boot_slot, good_slot, next_slot, trial_active;
    logic          boot_en, wdt_reset, upd_accept, upd_reject;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    boot_slot_sel #(.VER_W(VW), .TIMEOUT_CYC(TO), .INIT_VER(8'd0)) u_boot_slot_sel (
        .clk(clk), .por_n(por_n), .sys_boot(sys_boot), .upd_valid(upd_valid),
        .upd_version(upd_version), .fuse_floor(fuse_floor), .fw_alive(fw_alive),
        .boot_slot(boot_slot), .good_slot(good_slot), .next_slot(next_slot),
        .trial_active(trial_active), .boot_en(boot_en), .wdt_reset(wdt_reset),
        .upd_accept(upd_accept), .upd_reject(upd_reject)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic por();
        por_n = 1'b0; sys_boot = 0; upd_valid = 0; fw_alive = 0;
        upd_version = '0; fuse_floor = '0;
        step(); step();
        por_n = 1'b1;
        step();
    endtask

    task automatic update(input int v);
        upd_valid = 1'b1; upd_version = VW'(v);
        step();
        upd_valid = 1'b0;
    endtask

    task automatic boot();
        sys_boot = 1'b1;
        step();
        sys_boot = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1 reset state
        por();
        chk("R1 boot_slot", boot_slot, 0);
        chk("R1 good_slot", good_slot, 0);
        chk("R1 next_slot", next_slot, 0);
        chk("R1 trial", trial_active, 0);
        chk("R1 boot_en", boot_en, 1);
        chk("R1 pulses", {wdt_reset, upd_accept, upd_reject}, 0);

        // R2 R3: exhaustive sweep of version against floor
        for (int f = 0; f < (1 << VW); f++) begin
            for (int v = 0; v < (1 << VW); v++) begin
                por();
                fuse_floor = VW'(f);
                update(v);
                chk($sformatf("R2 R3 accept f=%0d v=%0d", f, v), upd_accept, (v >= f) ? 1 : 0);
                chk($sformatf("R3 reject f=%0d v=%0d", f, v), upd_reject, (v < f) ? 1 : 0);
                chk($sformatf("R2 next_slot f=%0d v=%0d", f, v), next_slot, (v >= f) ? 1 : 0);
                step();
                chk("R2 accept one cycle", {upd_accept, upd_reject}, 0);
            end
        end

        // R4: floor kept as running maximum
        por();
        fuse_floor = 4'd9; step();
        fuse_floor = 4'd2;
        update(5);
        chk("R4 lowered fuse still rejects", upd_reject, 1);
        chk("R4 no accept", upd_accept, 0);
        chk("R4 next_slot", next_slot, 0);

        // R9: update in same cycle as boot event is dropped
        por();
        sys_boot = 1'b1; upd_valid = 1'b1; upd_version = 4'd3;
        step();
        sys_boot = 1'b0; upd_valid = 1'b0;
        chk("R9 boot+update no pulse", {upd_accept, upd_reject}, 0);
        chk("R9 boot+update next_slot", next_slot, 0);
        chk("R9 boot+update trial", trial_active, 0);

        // R9: second update while pending is ignored
        por();
        update(2);
        update(3);
        chk("R9 pending blocks update", {upd_accept, upd_reject}, 0);
        chk("R9 pending next_slot", next_slot, 1);

        // R5 R7 R9: revert path
        por();
        update(2);
        boot();
        chk("R5 boot_slot trial", boot_slot, 1);
        chk("R5 trial_active", trial_active, 1);
        for (int i = 1; i < TO; i++) begin
            if (i == 2) begin
                upd_valid = 1'b1; upd_version = 4'd9;
            end
            step();
            if (i == 3) begin
                upd_valid = 1'b0;
                chk("R9 trial blocks update", {upd_accept, upd_reject}, 0);
                chk("R9 trial next_slot", next_slot, 0);
            end
            chk($sformatf("R7 no early wdt i=%0d", i), wdt_reset, 0);
            chk($sformatf("R7 trial held i=%0d", i), trial_active, 1);
        end
        step();
        chk("R7 wdt_reset at timeout", wdt_reset, 1);
        chk("R7 revert boot_slot", boot_slot, 0);
        chk("R7 good_slot kept", good_slot, 0);
        chk("R7 trial cleared", trial_active, 0);
        step();
        chk("R7 wdt single pulse", wdt_reset, 0);

        // R6: commit path
        por();
        update(5);
        boot();
        repeat (3) step();
        fw_alive = 1'b1; step(); fw_alive = 1'b0;
        chk("R6 good_slot committed", good_slot, 1);
        chk("R6 trial cleared", trial_active, 0);
        chk("R6 boot_slot", boot_slot, 1);
        for (int i = 0; i < TO + 2; i++) begin
            step();
            chk($sformatf("R6 no wdt after commit i=%0d", i), wdt_reset, 0);
        end
        chk("R6 next_slot", next_slot, 1);

        // R8: heartbeat in expiry cycle
        por();
        update(4);
        boot();
        repeat (TO - 1) step();
        fw_alive = 1'b1; step(); fw_alive = 1'b0;
        chk("R8 no wdt on collision", wdt_reset, 0);
        chk("R8 committed", good_slot, 1);
        chk("R8 trial cleared", trial_active, 0);
        chk("R8 boot_slot", boot_slot, 1);

        // R11: boot event during unconfirmed trial
        por();
        update(4);
        boot();
        repeat (2) step();
        boot();
        chk("R11 boot_slot reverted", boot_slot, 0);
        chk("R11 trial cleared", trial_active, 0);
        chk("R11 good_slot", good_slot, 0);
        chk("R11 no wdt", wdt_reset, 0);

        // R10: floor raised between acceptance and boot
        por();
        update(7);
        boot();
        fw_alive = 1'b1; step(); fw_alive = 1'b0;
        update(3);
        chk("R10 accept slot0 image", upd_accept, 1);
        fuse_floor = 4'd5; step();
        boot();
        chk("R10 low trial refused", trial_active, 0);
        chk("R10 good boots", boot_slot, 1);
        chk("R10 boot_en", boot_en, 1);
        fuse_floor = 4'd8; step();
        boot();
        chk("R10 nothing bootable", boot_en, 0);
        chk("R10 halted trial", trial_active, 0);

        finish_run();
    end
endmodule